// File: doc/BRIEF.md
# Companded Successive-Approximation PCM Encoder

This block turns one signed linear sample into an 8-bit logarithmic PCM byte. After a start request it decides the sign first. It then makes seven binary decisions, most significant bit first: three for the chord (segment) and four for the step inside that chord. Each decision forms a trial code from the bits already settled, with the current bit set to one. The trial code goes through a decode law (mu-law or A-law, chosen per conversion) to give a linear threshold. The bit stays set when the sample magnitude is at least that threshold. Comparators and capacitor arrays are replaced by integer arithmetic with one extra fractional bit, so every half-step term is exact.

The settled byte then passes through a line coder. The coder leaves it as sign-magnitude, inverts the seven magnitude bits, or inverts the even-numbered bits. The surrounding system starts one conversion per 8 kHz frame. A controller with five states sequences the work:
- `ST_IDLE` waits for a start.
- `ST_SIGN` fixes the sign and magnitude.
- `ST_CHORD` runs three chord decisions.
- `ST_STEP` runs four step decisions.
- `ST_DONE` lasts one cycle and reports completion.

The transitions are IDLE→SIGN on start, SIGN→CHORD always, CHORD→STEP after the lowest chord bit, STEP→DONE after bit 0, DONE→SIGN on a new start and DONE→IDLE otherwise.

Top module: `log_sar_encoder`

## Requirements
- R1: A start seen in `ST_IDLE` or `ST_DONE` makes `busy_o` high for exactly 8 consecutive cycles, starting with the cycle after the start edge. One cycle with `done_o` high follows. `busy_o` and `done_o` are never high together.
- R2: A start that arrives while `busy_o` is high is ignored. The running conversion finishes on its normal schedule with the sample captured at its own start.
- R3: Output byte layout before line coding: bit 7 is 1 for a negative sample and 0 for zero or positive, bits 6..4 hold the chord C, bits 3..0 hold the step S. The magnitude field is the largest 7-bit code whose trial level is at or below |sample|.
- R4: Mu-law trial level, with law input 0 and in half units: 2^C·(33+2S) − 33. This is twice 2^C·(16.5+S) − 16.5.
- R5: A-law trial level, with law input 1 and in half units: 2·(2S+1) for C = 0, and 2^C·(33+2S) for C ≥ 1.
- R6: A magnitude at or above the largest trial level gives chord 7, step 15. This includes the most negative sample, −8192. With format 0 the results are 0x7F and 0xFF. With format 2 they are 0x2A and 0xAA.
- R7: Format codes 0 and 3 output the raw sign-magnitude byte.
- R8: Format code 1 keeps bit 7 and inverts bits 6..0 (XOR 0x7F).
- R9: Format code 2 inverts bits 6, 4, 2 and 0 (XOR 0x55).
- R10: Sample, law and format are captured at the accepted start. Changes on those inputs later in the conversion have no effect. `code_o` changes only on the edge that raises `done_o` and holds its value until the next conversion finishes.
- R11: After reset `busy_o`, `done_o` and `code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| sample_i | input | SAMPLE_W | Two's-complement linear sample |
| law_i | input | 1 | Decode law: 0 mu-law, 1 A-law |
| fmt_i | input | 2 | Line format: 0/3 plain, 1 inverted magnitude, 2 even-bit inversion |
| busy_o | output | 1 | High during the 8 decision cycles |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 8 | Formatted PCM byte |

## Verification
The bench sweeps the full input range at a fine stride under both laws and rotates all four format codes. It also drives the exact chord-edge and overload values. A threshold off by one half-step, or a wrong mu-law bias, shows up as a step miscoded by one. A chord-0 A-law error shows up as mis-coded small signals. A wrong sign on −8192 or on zero flips bit 7. Starts during a conversion, and input changes after the start, would corrupt the result or stretch `busy_o` in a design that fails to ignore them. A result register that updates early shows up as a code change outside the done cycle.

// File: rtl/logenc_pkg.sv
package logenc_pkg;
    localparam int CODE_W    = 8;
    localparam int CHORD_W   = 3;
    localparam int STEP_W    = 4;
    localparam int NATIVE_W  = 14;
    localparam int MU_BIAS   = 33;
    localparam int LEVEL_TOP = 8064;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIGN,
        ST_CHORD,
        ST_STEP,
        ST_DONE
    } enc_state_e;

    typedef enum logic [1:0] {
        FMT_PLAIN  = 2'd0,
        FMT_INVMAG = 2'd1,
        FMT_ALTINV = 2'd2,
        FMT_ALIAS  = 2'd3
    } line_fmt_e;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;
endpackage

// File: rtl/trial_level.sv
module trial_level
    import logenc_pkg::*;
#(
    parameter int MAG_W = 14
) (
    input  law_e               law,
    input  logic [CHORD_W-1:0] chord,
    input  logic [STEP_W-1:0]  step,
    output logic [MAG_W-1:0]   level
);
    localparam int SCALE_SH = MAG_W - NATIVE_W;

    logic [NATIVE_W-1:0] mant;
    logic [NATIVE_W-1:0] shifted;
    logic [NATIVE_W-1:0] native;

    // Half-unit arithmetic: every x.5 term of the decode law becomes an integer.
    always_comb begin
        mant    = NATIVE_W'(MU_BIAS) + NATIVE_W'({step, 1'b0});
        shifted = mant << chord;
        if (law == LAW_A) begin
            native = (chord == '0) ? (NATIVE_W'({step, 1'b1}) << 1) : shifted;
        end else begin
            native = shifted - NATIVE_W'(MU_BIAS);
        end
        level = MAG_W'(native) << SCALE_SH;
    end
endmodule

// File: rtl/line_coder.sv
module line_coder
    import logenc_pkg::*;
(
    input  logic [1:0]        fmt,
    input  logic [CODE_W-1:0] raw,
    output logic [CODE_W-1:0] coded
);
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        localparam bit IS_MAG  = (b < CODE_W - 1);
        localparam bit IS_EVEN = ((b % 2) == 0);
        logic flip;

        always_comb begin
            case (line_fmt_e'(fmt))
                FMT_INVMAG: flip = IS_MAG;
                FMT_ALTINV: flip = IS_EVEN;
                default:    flip = 1'b0;
            endcase
        end

        assign coded[b] = raw[b] ^ flip;
    end
endmodule

// File: rtl/log_sar_encoder.sv
module log_sar_encoder
    import logenc_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                law_i,
    input  logic [1:0]          fmt_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [CODE_W-1:0]   code_o
);
    localparam int MAG_W    = SAMPLE_W;
    localparam int MC_W     = CODE_W - 1;
    localparam int PTR_W    = $clog2(MC_W);
    localparam int SCALE_SH = SAMPLE_W - NATIVE_W;
    localparam logic [PTR_W-1:0] PTR_TOP   = PTR_W'(MC_W - 1);
    localparam logic [PTR_W-1:0] PTR_CHEND = PTR_W'(STEP_W);
    localparam logic [MAG_W-1:0] FULL_LVL  = MAG_W'(LEVEL_TOP) << SCALE_SH;

    enc_state_e          state_q, state_d;
    logic [SAMPLE_W-1:0] sample_q;
    law_e                law_q;
    logic [1:0]          fmt_q;
    logic                sign_q;
    logic [MAG_W-1:0]    mag_q;
    logic [MC_W-1:0]     mag_code_q;
    logic [PTR_W-1:0]    ptr_q;
    logic [CODE_W-1:0]   code_q;

    logic                accept;
    logic [MC_W-1:0]     trial_code;
    logic [MC_W-1:0]     next_code;
    logic [MAG_W-1:0]    trial_lvl;
    logic [CODE_W-1:0]   coded;

    assign accept     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign trial_code = mag_code_q | (MC_W'(1) << ptr_q);
    assign next_code  = (mag_q >= trial_lvl) ? trial_code : mag_code_q;

    trial_level #(.MAG_W(MAG_W)) u_trial (
        .law   (law_q),
        .chord (trial_code[MC_W-1:STEP_W]),
        .step  (trial_code[STEP_W-1:0]),
        .level (trial_lvl)
    );

    line_coder u_coder (
        .fmt   (fmt_q),
        .raw   ({sign_q, next_code}),
        .coded (coded)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SIGN;
            ST_SIGN:  state_d = ST_CHORD;
            ST_CHORD: if (ptr_q == PTR_CHEND) state_d = ST_STEP;
            ST_STEP:  if (ptr_q == '0) state_d = ST_DONE;
            ST_DONE:  state_d = start_i ? ST_SIGN : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q   <= '0;
            law_q      <= LAW_MU;
            fmt_q      <= '0;
            sign_q     <= 1'b0;
            mag_q      <= '0;
            mag_code_q <= '0;
            ptr_q      <= '0;
            code_q     <= '0;
        end else begin
            if (accept) begin
                sample_q <= sample_i;
                law_q    <= law_e'(law_i);
                fmt_q    <= fmt_i;
            end
            if (state_q == ST_SIGN) begin
                sign_q     <= sample_q[SAMPLE_W-1];
                mag_q      <= sample_q[SAMPLE_W-1] ? (~sample_q + 1'b1) : sample_q;
                mag_code_q <= '0;
                ptr_q      <= PTR_TOP;
            end
            if (state_q == ST_CHORD || state_q == ST_STEP) begin
                mag_code_q <= next_code;
                ptr_q      <= ptr_q - 1'b1;
            end
            if (state_q == ST_STEP && ptr_q == '0) begin
                code_q <= coded;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o = (state_q == ST_SIGN) || (state_q == ST_CHORD) || (state_q == ST_STEP);
        done_o = (state_q == ST_DONE);
        code_o = code_q;
    end

    // Assertions
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    assert_start_to_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    assert_restart_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sample_q));
    assert_chord_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && $past(state_q) == ST_STEP) |-> $stable(mag_code_q[MC_W-1:STEP_W]));
    assert_level_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHORD || state_q == ST_STEP) |-> (trial_lvl <= FULL_LVL));
    assert_sign_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fmt_q == FMT_INVMAG) |-> (code_o[CODE_W-1] == sign_q));
    assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> done_o);
endmodule

// File: tb/log_sar_encoder_bench.sv
module log_sar_encoder_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [13:0] sample;
    logic       law;
    logic [1:0] fmt;
    logic       busy_o, done_o;
    logic [7:0] code_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    log_sar_encoder u_log_sar_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sample_i(sample),
        .law_i(law), .fmt_i(fmt), .busy_o(busy_o), .done_o(done_o), .code_o(code_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Largest 7-bit code whose decode threshold (half units) is <= mag.
    function automatic int ref_mag(input int mag, input bit lw);
        int best = 0;
        for (int cd = 0; cd < 128; cd++) begin
            int  c = cd / 16;
            int  s = cd % 16;
            real t;
            if (!lw)        t = 2.0 * ((2.0 ** c) * (16.5 + s) - 16.5);
            else if (c == 0) t = 4.0 * (0.5 + s);
            else            t = 2.0 * (2.0 ** c) * (16.5 + s);
            if (real'(mag) >= t) best = cd;
        end
        return best;
    endfunction

    function automatic int exp_code(input int x, input bit lw, input logic [1:0] fm);
        int raw = ((x < 0) ? 128 : 0) + ref_mag((x < 0) ? -x : x, lw);
        int mask = (fm == 2'd1) ? 8'h7F : ((fm == 2'd2) ? 8'h55 : 8'h00);
        return raw ^ mask;
    endfunction

    task automatic run_conv(input int x, input bit lw, input logic [1:0] fm, input bit poke,
                            output logic [7:0] got, output int bcnt, output bit found,
                            output bit done_one);
        @(negedge clk);
        start = 1'b1; sample = 14'(x); law = lw; fmt = fm;
        @(negedge clk);
        start = 1'b0; sample = ~sample; law = ~lw; fmt = fm + 2'd1;
        bcnt = 0; got = '0; found = 1'b0; done_one = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if (done_o) begin
                got = code_o; found = 1'b1;
                break;
            end
            if (busy_o) bcnt++;
            start = poke && (n == 2);
            if (poke && n == 2) sample = 14'(x ^ 14'h2A5);
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        done_one = !done_o;
    endtask

    task automatic vec(input int x, input bit lw, input logic [1:0] fm, input string tag);
        logic [7:0] got;
        int bcnt;
        bit found, done_one;
        int e;
        run_conv(x, lw, fm, 1'b0, got, bcnt, found, done_one);
        e = exp_code(x, lw, fm);
        check(found, "R1 done timeout", 0, 1);
        check(int'(got) == e, tag, int'(got), e);
        check(bcnt == 8 && done_one, "R1 busy/done timing", bcnt, 8);
    endtask

    function automatic string fmt_tag(input logic [1:0] fm);
        case (fm)
            2'd1:    return "R8";
            2'd2:    return "R9";
            default: return "R7";
        endcase
    endfunction

    initial begin
        logic [7:0] got;
        int bcnt;
        bit found, done_one;

        rst_n = 1'b0; start = 1'b0; sample = '0; law = 1'b0; fmt = '0;
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R11 busy", busy_o, 0);
        check(done_o == 1'b0, "R11 done", done_o, 0);
        check(code_o == 8'h00, "R11 code", code_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: sign of zero and of -1
        vec(0, 1'b0, 2'd0, "R3 zero");
        vec(-1, 1'b0, 2'd0, "R3 minus one");
        run_conv(0, 1'b0, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h00, "R3 zero literal", got, 8'h00);
        run_conv(-1, 1'b1, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h80, "R3 minus one literal", got, 8'h80);

        // R6: overload and saturation with literal expectations
        run_conv(8191, 1'b0, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h7F, "R6 mu max fmt0", got, 8'h7F);
        run_conv(-8192, 1'b0, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'hFF, "R6 mu min fmt0", got, 8'hFF);
        run_conv(8191, 1'b1, 2'd2, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h2A, "R6 A max fmt2", got, 8'h2A);
        run_conv(-8192, 1'b1, 2'd2, 1'b0, got, bcnt, found, done_one);
        check(got == 8'hAA, "R6 A min fmt2", got, 8'hAA);
        run_conv(8031, 1'b0, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h7F, "R6 R4 mu top threshold", got, 8'h7F);
        run_conv(8030, 1'b0, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h7E, "R4 just below mu top", got, 8'h7E);
        run_conv(8064, 1'b1, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h7F, "R6 R5 A top threshold", got, 8'h7F);
        run_conv(8063, 1'b1, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h7E, "R5 just below A top", got, 8'h7E);
        run_conv(66, 1'b1, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h10, "R5 A chord1 start", got, 8'h10);
        run_conv(65, 1'b1, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h0F, "R5 A chord0 top", got, 8'h0F);
        run_conv(33, 1'b0, 2'd0, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h10, "R4 mu chord1 start", got, 8'h10);
        run_conv(8191, 1'b0, 2'd1, 1'b0, got, bcnt, found, done_one);
        check(got == 8'h00, "R8 mu max fmt1", got, 8'h00);
        run_conv(-8192, 1'b0, 2'd3, 1'b0, got, bcnt, found, done_one);
        check(got == 8'hFF, "R7 fmt3 alias", got, 8'hFF);

        // R2: start pulse in the middle of a conversion is ignored
        run_conv(8191, 1'b0, 2'd0, 1'b1, got, bcnt, found, done_one);
        check(got == 8'h7F, "R2 restart ignored code", got, 8'h7F);
        check(bcnt == 8 && done_one, "R2 restart ignored timing", bcnt, 8);

        // R10: result holds while inputs wander and no start is given
        run_conv(-300, 1'b1, 2'd2, 1'b0, got, bcnt, found, done_one);
        check(int'(got) == exp_code(-300, 1'b1, 2'd2), "R10 latched inputs", got,
              exp_code(-300, 1'b1, 2'd2));
        for (int k = 0; k < 5; k++) begin
            sample = 14'(k * 977); fmt = 2'(k); law = k[0];
            @(negedge clk);
            check(code_o == got, "R10 hold", code_o, got);
            check(done_o == 1'b0, "R10 no done", done_o, 0);
        end

        // Near-exhaustive sweep over both laws, all formats rotated
        for (int lw = 0; lw < 2; lw++) begin
            int idx = 0;
            for (int x = -8192; x <= 8191; x += 5) begin
                logic [1:0] fm = 2'(idx % 4);
                vec(x, lw[0], fm, $sformatf("%s/%s/R3 x=%0d", lw ? "R5" : "R4", fmt_tag(fm), x));
                idx++;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule